// File: doc/BRIEF.md
# SCSI Target Selection Detector

This block watches a SCSI bus on behalf of a device that answers to up to eight target IDs. It decides when a host has picked one of them. The bus pins are active-low. Each one passes through a two-stage synchroniser before use.

A selection candidate is checked on two edges: when SEL becomes active, and when BSY stops being active. This lets a lone SCSI-1 host that raises SEL without first holding BSY still be detected. At that moment, SEL must be active and BSY idle. The data-bus bits are then compared with a table of configured IDs. On a hit, the block drives BSY and latches a status word and a sticky selected flag. A fixed delay later it looks at ATN. If ATN is idle, the host is treated as SCSI-1: the attention bit is cleared and a compatibility flag is raised.

A separate filter confirms a bus reset only if RST is still active a set time after it first went active.

The surrounding controller uses two strobes:
- `busFree` ends the session, releasing BSY and clearing the selection state.
- `resetAck` acknowledges a reported reset.

Top module: `scsi_sel_detect`

## Requirements
- R1: After chip reset, `bsyOutN` is 1, `selStatus` is 0, and `selectedFlag`, `scsi1Mode` and `resetFlag` are 0.
- R2: With BSY idle, a new SEL assertion whose data bits hit a configured ID is accepted. This is the single-initiator case, with no prior BSY from the host.
- R3: While SEL is held, a release of BSY by the host is accepted as a selection when the data bits hit a configured ID.
- R4: `selStatus` layout: bit 7 means selection succeeded; bit 6 means attention, and it is set when the selection is taken; bits 2:0 hold the chosen ID; bits 5:3 are always 0. A data bit n counts when its pin is low. Among table entries that are enabled and have an ID of 7 or less, the lowest index whose ID bit is set wins. Disabled entries and entries with an ID above 7 never match.
- R5: When no entry matches, `selStatus` stays 0 and `bsyOutN` stays 1.
- R6: On a selection, `bsyOutN` goes to 0. ATN_DELAY_NS later, ATN is sampled. If ATN is idle, bit 6 clears and `scsi1Mode` becomes 1. If ATN is active, bit 6 stays set and `scsi1Mode` stays 0.
- R7: `selectedFlag` stays set after the host drops SEL, until the session ends.
- R8: While the block drives BSY, SEL and BSY edges are ignored; the status word does not change.
- R9: An RST pulse shorter than RST_FILTER_NS is ignored. A longer one sets `resetFlag`, releases BSY, and clears `selStatus`, `selectedFlag` and `scsi1Mode`.
- R10: A `busFree` pulse releases BSY and clears `selStatus`, `selectedFlag` and `scsi1Mode`. A `resetAck` pulse clears `resetFlag`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rstN | input | 1 | Chip reset, active low |
| busSelN | input | 1 | SEL pin, active low |
| busBsyN | input | 1 | BSY pin as seen on the bus, active low |
| busAtnN | input | 1 | ATN pin, active low |
| busRstN | input | 1 | RST pin, active low |
| busDataN | input | 8 | Data bus pins, active low |
| cfgTargetId | input | NUM_TARGETS*ID_W | Packed table of target IDs, entry 0 in the low bits |
| cfgTargetEn | input | NUM_TARGETS | Enable per table entry |
| busFree | input | 1 | Strobe that ends the session |
| resetAck | input | 1 | Strobe that clears the reset flag |
| bsyOutN | output | 1 | BSY drive, active low |
| selStatus | output | 8 | Selection status word |
| selectedFlag | output | 1 | Sticky selected flag |
| scsi1Mode | output | 1 | SCSI-1 compatibility flag |
| resetFlag | output | 1 | Confirmed bus reset |

## Verification
The properties assume three things about the inputs:
- The bus BSY pin reflects the block's own drive, as on a wired-OR line.
- `busFree` arrives only as a single-cycle strobe.
- The host takes SEL away before the session is ended, whether by `busFree` or by a bus reset. Otherwise the release of BSY would count as a fresh selection edge.

The bench models the bus as the AND of host and target drivers. It always drops SEL before ending a session. It changes pins only on falling clock edges, holding each level for many cycles so that the synchronisers settle.

// File: rtl/scsi_sel_pkg.sv
package scsi_sel_pkg;
  typedef struct packed {
    logic latchSel;
    logic sampleAtn;
    logic clearSel;
    logic setRstFlag;
  } selStrobes_t;

  localparam int STS_OK_BIT  = 7;
  localparam int STS_ATN_BIT = 6;
endpackage

// File: rtl/scsi_sel_sync.sv
module scsi_sel_sync #(
  parameter int W = 4
) (
  input  logic         clk,
  input  logic         rstN,
  input  logic [W-1:0] pinIn,
  output logic [W-1:0] pinOut
);
  logic [W-1:0] stage1;
  logic [W-1:0] stage2;

  // Pins idle high, so the flops reset to all ones.
  for (genvar b = 0; b < W; b++) begin : g_bit
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        stage1[b] <= 1'b1;
        stage2[b] <= 1'b1;
      end else begin
        stage1[b] <= pinIn[b];
        stage2[b] <= stage1[b];
      end
    end
  end

  assign pinOut = stage2;
endmodule

// File: rtl/scsi_sel_datapath.sv
module scsi_sel_datapath
  import scsi_sel_pkg::*;
#(
  parameter int NUM_TARGETS = 8,
  parameter int ID_W        = 4
) (
  input  logic                        clk,
  input  logic                        rstN,
  input  logic                        busSelN,
  input  logic                        busBsyN,
  input  logic                        busAtnN,
  input  logic                        busRstN,
  input  logic [7:0]                  busDataN,
  input  logic [NUM_TARGETS*ID_W-1:0] cfgTargetId,
  input  logic [NUM_TARGETS-1:0]      cfgTargetEn,
  input  logic                        resetAck,
  input  selStrobes_t                 strobes,
  output logic                        selHit,
  output logic                        atnNow,
  output logic                        rstEdge,
  output logic                        rstNow,
  output logic                        bsyOutN,
  output logic [7:0]                  selStatus,
  output logic                        selectedFlag,
  output logic                        scsi1Mode,
  output logic                        resetFlag
);
  localparam int SYNC_W = 12;

  logic [SYNC_W-1:0] syncOut;
  logic [7:0]        dataAct;
  logic              selAct, bsyAct, atnAct, rstAct;
  logic              selPrev, bsyPrev, rstPrev;
  logic              selEdge, bsyRelEdge;
  logic              bsyDrive;

  scsi_sel_sync #(.W(SYNC_W)) u_sync (
    .clk    (clk),
    .rstN   (rstN),
    .pinIn  ({busDataN, busSelN, busBsyN, busAtnN, busRstN}),
    .pinOut (syncOut)
  );

  assign dataAct = ~syncOut[11:4];
  assign selAct  = ~syncOut[3];
  assign bsyAct  = ~syncOut[2];
  assign atnAct  = ~syncOut[1];
  assign rstAct  = ~syncOut[0];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      selPrev <= 1'b0;
      bsyPrev <= 1'b0;
      rstPrev <= 1'b0;
    end else begin
      selPrev <= selAct;
      bsyPrev <= bsyAct;
      rstPrev <= rstAct;
    end
  end

  assign selEdge    = selAct & ~selPrev;
  assign bsyRelEdge = ~bsyAct & bsyPrev;
  assign rstEdge    = rstAct & ~rstPrev;
  assign rstNow     = rstAct;
  assign atnNow     = atnAct;

  // Per-entry match against the data bus.
  logic [ID_W-1:0]        entryId [NUM_TARGETS];
  logic [NUM_TARGETS-1:0] entryHit;

  for (genvar i = 0; i < NUM_TARGETS; i++) begin : g_entry
    assign entryId[i]  = cfgTargetId[i*ID_W +: ID_W];
    assign entryHit[i] = cfgTargetEn[i]
                       && (entryId[i][ID_W-1:3] == '0)
                       && dataAct[entryId[i][2:0]];
  end

  // Lowest table index takes priority.
  logic       matchValid;
  logic [2:0] matchId;

  always_comb begin
    matchValid = 1'b0;
    matchId    = 3'd0;
    for (int i = NUM_TARGETS - 1; i >= 0; i--) begin
      if (entryHit[i]) begin
        matchValid = 1'b1;
        matchId    = entryId[i][2:0];
      end
    end
  end

  assign selHit = (selEdge | bsyRelEdge) & selAct & ~bsyAct & ~bsyDrive & matchValid;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      bsyDrive     <= 1'b0;
      selStatus    <= 8'h00;
      selectedFlag <= 1'b0;
      scsi1Mode    <= 1'b0;
    end else if (strobes.clearSel) begin
      bsyDrive     <= 1'b0;
      selStatus    <= 8'h00;
      selectedFlag <= 1'b0;
      scsi1Mode    <= 1'b0;
    end else if (strobes.latchSel) begin
      bsyDrive     <= 1'b1;
      selStatus    <= {1'b1, 1'b1, 3'b000, matchId};
      selectedFlag <= 1'b1;
    end else if (strobes.sampleAtn && !atnAct) begin
      selStatus[STS_ATN_BIT] <= 1'b0;
      scsi1Mode              <= 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                   resetFlag <= 1'b0;
    else if (strobes.setRstFlag) resetFlag <= 1'b1;
    else if (resetAck)           resetFlag <= 1'b0;
  end

  assign bsyOutN = ~bsyDrive;
endmodule

// File: rtl/scsi_sel_control.sv
module scsi_sel_control
  import scsi_sel_pkg::*;
#(
  parameter int CLK_PERIOD_NS = 10,
  parameter int ATN_DELAY_NS  = 100,
  parameter int RST_FILTER_NS = 500
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        selHit,
  input  logic        rstEdge,
  input  logic        rstNow,
  input  logic        busFree,
  output selStrobes_t strobes
);
  localparam int ATN_CYCLES = (ATN_DELAY_NS + CLK_PERIOD_NS - 1) / CLK_PERIOD_NS;
  localparam int RST_CYCLES = (RST_FILTER_NS + CLK_PERIOD_NS - 1) / CLK_PERIOD_NS;
  localparam int ATN_W      = $clog2(ATN_CYCLES + 1);
  localparam int RST_W      = $clog2(RST_CYCLES + 1);

  typedef enum logic [1:0] {S_IDLE, S_ATNWAIT, S_OWNED} selState_t;
  typedef enum logic {RF_IDLE, RF_WAIT} rfState_t;

  selState_t        state, stateNext;
  rfState_t         rfState;
  logic [ATN_W-1:0] atnCnt;
  logic [RST_W-1:0] rfCnt;
  logic             atnDone, rfDone, rstConfirm;

  assign atnDone    = (atnCnt == ATN_W'(ATN_CYCLES - 1));
  assign rfDone     = (rfCnt == RST_W'(RST_CYCLES - 1));
  assign rstConfirm = (rfState == RF_WAIT) && rfDone && rstNow;

  always_comb begin
    strobes            = '0;
    strobes.setRstFlag = rstConfirm;
    strobes.clearSel   = rstConfirm | busFree;
    strobes.latchSel   = (state == S_IDLE) && selHit && !strobes.clearSel;
    strobes.sampleAtn  = (state == S_ATNWAIT) && atnDone && !strobes.clearSel;
  end

  always_comb begin
    stateNext = state;
    if (strobes.clearSel) stateNext = S_IDLE;
    else begin
      case (state)
        S_IDLE:    if (strobes.latchSel) stateNext = S_ATNWAIT;
        S_ATNWAIT: if (atnDone)          stateNext = S_OWNED;
        default:   stateNext = state;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state  <= S_IDLE;
      atnCnt <= '0;
    end else begin
      state <= stateNext;
      if (state == S_ATNWAIT && stateNext == S_ATNWAIT) atnCnt <= atnCnt + 1'b1;
      else                                              atnCnt <= '0;
    end
  end

  // Reset glitch filter: second look at RST after the filter window.
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rfState <= RF_IDLE;
      rfCnt   <= '0;
    end else begin
      case (rfState)
        RF_IDLE: begin
          rfCnt <= '0;
          if (rstEdge) rfState <= RF_WAIT;
        end
        default: begin
          if (rfDone) begin
            rfState <= RF_IDLE;
            rfCnt   <= '0;
          end else begin
            rfCnt <= rfCnt + 1'b1;
          end
        end
      endcase
    end
  end
endmodule

// File: rtl/scsi_sel_detect.sv
module scsi_sel_detect
  import scsi_sel_pkg::*;
#(
  parameter int NUM_TARGETS   = 8,
  parameter int ID_W          = 4,
  parameter int CLK_PERIOD_NS = 10,
  parameter int ATN_DELAY_NS  = 100,
  parameter int RST_FILTER_NS = 500
) (
  input  logic                        clk,
  input  logic                        rstN,
  input  logic                        busSelN,
  input  logic                        busBsyN,
  input  logic                        busAtnN,
  input  logic                        busRstN,
  input  logic [7:0]                  busDataN,
  input  logic [NUM_TARGETS*ID_W-1:0] cfgTargetId,
  input  logic [NUM_TARGETS-1:0]      cfgTargetEn,
  input  logic                        busFree,
  input  logic                        resetAck,
  output logic                        bsyOutN,
  output logic [7:0]                  selStatus,
  output logic                        selectedFlag,
  output logic                        scsi1Mode,
  output logic                        resetFlag
);
  selStrobes_t strobes;
  logic        selHit, atnNow, rstEdge, rstNow;

  scsi_sel_datapath #(.NUM_TARGETS(NUM_TARGETS), .ID_W(ID_W)) u_dp (
    .clk          (clk),
    .rstN         (rstN),
    .busSelN      (busSelN),
    .busBsyN      (busBsyN),
    .busAtnN      (busAtnN),
    .busRstN      (busRstN),
    .busDataN     (busDataN),
    .cfgTargetId  (cfgTargetId),
    .cfgTargetEn  (cfgTargetEn),
    .resetAck     (resetAck),
    .strobes      (strobes),
    .selHit       (selHit),
    .atnNow       (atnNow),
    .rstEdge      (rstEdge),
    .rstNow       (rstNow),
    .bsyOutN      (bsyOutN),
    .selStatus    (selStatus),
    .selectedFlag (selectedFlag),
    .scsi1Mode    (scsi1Mode),
    .resetFlag    (resetFlag)
  );

  scsi_sel_control #(
    .CLK_PERIOD_NS (CLK_PERIOD_NS),
    .ATN_DELAY_NS  (ATN_DELAY_NS),
    .RST_FILTER_NS (RST_FILTER_NS)
  ) u_ctl (
    .clk     (clk),
    .rstN    (rstN),
    .selHit  (selHit),
    .rstEdge (rstEdge),
    .rstNow  (rstNow),
    .busFree (busFree),
    .strobes (strobes)
  );

  logic unusedAtn;
  assign unusedAtn = atnNow;
endmodule

// File: rtl/scsi_sel_detect_chk.sv
module scsi_sel_detect_chk (
  input logic       clk,
  input logic       rstN,
  input logic       busFree,
  input logic       bsyOutN,
  input logic [7:0] selStatus,
  input logic       selectedFlag,
  input logic       scsi1Mode,
  input logic       resetFlag
);
  AST_BSY_TRACKS_STATUS: assert property (@(posedge clk) disable iff (!rstN)
    bsyOutN == !selStatus[7]); // R6

  AST_STATUS_GAP_ZERO: assert property (@(posedge clk) disable iff (!rstN)
    selStatus[5:3] == 3'b000); // R4

  AST_SCSI1_NO_ATN: assert property (@(posedge clk) disable iff (!rstN)
    scsi1Mode |-> !selStatus[6]); // R6

  AST_SELECTED_STICKY: assert property (@(posedge clk) disable iff (!rstN)
    selStatus[7] |-> selectedFlag); // R7

  AST_RESET_RELEASES: assert property (@(posedge clk) disable iff (!rstN)
    $rose(resetFlag) |-> (bsyOutN && selStatus == 8'h00 && !selectedFlag)); // R9

  AST_BUSFREE_CLEARS: assert property (@(posedge clk) disable iff (!rstN)
    busFree |=> (bsyOutN && selStatus == 8'h00 && !scsi1Mode)); // R10
endmodule

bind scsi_sel_detect scsi_sel_detect_chk u_chk (
  .clk          (clk),
  .rstN         (rstN),
  .busFree      (busFree),
  .bsyOutN      (bsyOutN),
  .selStatus    (selStatus),
  .selectedFlag (selectedFlag),
  .scsi1Mode    (scsi1Mode),
  .resetFlag    (resetFlag)
);

// File: tb/scsi_sel_detect_tb.sv
module scsi_sel_detect_tb;
  localparam int NT = 8;
  localparam int IW = 4;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic hostSelN = 1'b1, hostBsyN = 1'b1, hostAtnN = 1'b1, hostRstN = 1'b1;
  logic [7:0] hostDataN = 8'hFF;
  logic [NT*IW-1:0] cfgTargetId;
  logic [NT-1:0] cfgTargetEn;
  logic busFree = 1'b0, resetAck = 1'b0;
  logic bsyOutN, selectedFlag, scsi1Mode, resetFlag;
  logic [7:0] selStatus;
  logic busBsyN;

  int compared = 0;
  int mismatched = 0;

  always #5 clk = ~clk;

  assign busBsyN = hostBsyN & bsyOutN;

  scsi_sel_detect u_dut (
    .clk(clk), .rstN(rstN),
    .busSelN(hostSelN), .busBsyN(busBsyN), .busAtnN(hostAtnN), .busRstN(hostRstN),
    .busDataN(hostDataN), .cfgTargetId(cfgTargetId), .cfgTargetEn(cfgTargetEn),
    .busFree(busFree), .resetAck(resetAck),
    .bsyOutN(bsyOutN), .selStatus(selStatus), .selectedFlag(selectedFlag),
    .scsi1Mode(scsi1Mode), .resetFlag(resetFlag)
  );

  task automatic waitCyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(input string req, input string what, input logic [7:0] act, input logic [7:0] exp);
    compared++;
    if (act !== exp) begin
      mismatched++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic pulseBusFree();
    busFree = 1'b1; waitCyc(1); busFree = 1'b0; waitCyc(2);
  endtask

  task automatic tReset();
    chk("R1", "bsyOutN", {7'd0, bsyOutN}, 8'd1);
    chk("R1", "selStatus", selStatus, 8'h00);
    chk("R1", "flags", {5'd0, selectedFlag, scsi1Mode, resetFlag}, 8'h00);
  endtask

  // Single-initiator selection, ATN idle -> SCSI-1.
  task automatic tScsi1Select();
    hostDataN = ~8'b1000_1000; hostAtnN = 1'b1; waitCyc(2);
    hostSelN = 1'b0; waitCyc(6);
    chk("R2", "status early", selStatus, 8'hC3);
    chk("R6", "bsy driven", {7'd0, bsyOutN}, 8'd0);
    waitCyc(20);
    chk("R6", "status after atn", selStatus, 8'h83);
    chk("R6", "scsi1Mode", {7'd0, scsi1Mode}, 8'd1);
    hostSelN = 1'b1; hostDataN = 8'hFF; waitCyc(10);
    chk("R7", "selectedFlag", {7'd0, selectedFlag}, 8'd1);
    pulseBusFree();
    chk("R10", "status cleared", selStatus, 8'h00);
    chk("R10", "bsy released", {7'd0, bsyOutN}, 8'd1);
    chk("R10", "flags cleared", {6'd0, selectedFlag, scsi1Mode}, 8'h00);
  endtask

  // Host holds BSY, then releases it; ATN active keeps SCSI-2.
  task automatic tScsi2Select();
    hostBsyN = 1'b0; hostDataN = ~8'b1010_0000; hostAtnN = 1'b0; waitCyc(2);
    hostSelN = 1'b0; waitCyc(10);
    chk("R3", "no select while BSY held", selStatus, 8'h00);
    hostBsyN = 1'b1; waitCyc(30);
    chk("R3", "status", selStatus, 8'hC5);
    chk("R6", "scsi1Mode stays 0", {7'd0, scsi1Mode}, 8'd0);
    // R8: edges while driving BSY are ignored
    hostSelN = 1'b1; waitCyc(5);
    hostDataN = ~8'b1000_1000; hostSelN = 1'b0; waitCyc(10);
    chk("R8", "status unchanged", selStatus, 8'hC5);
    hostSelN = 1'b1; hostAtnN = 1'b1; hostDataN = 8'hFF; waitCyc(5);
    pulseBusFree(); waitCyc(5);
    chk("R10", "status cleared", selStatus, 8'h00);
  endtask

  task automatic tryData(input string req, input logic [7:0] bits, input logic [7:0] exp);
    hostDataN = ~bits; waitCyc(2);
    hostSelN = 1'b0; waitCyc(8);
    chk(req, $sformatf("status bits=%h", bits), selStatus, exp);
    chk(req, "bsy", {7'd0, bsyOutN}, (exp == 8'h00) ? 8'd1 : 8'd0);
    hostSelN = 1'b1; hostDataN = 8'hFF; waitCyc(5);
    pulseBusFree(); waitCyc(3);
  endtask

  task automatic tPriority();
    tryData("R4", 8'b1010_1000, 8'hC3);  // IDs 3 and 5: entry 0 (ID 3) wins
    tryData("R4", 8'b1000_0010, 8'h00);  // entry with ID 9 must not alias to 1
    tryData("R5", 8'b1100_0000, 8'h00);  // ID 6 entry disabled
  endtask

  task automatic tBusReset();
    hostRstN = 1'b0; waitCyc(20); hostRstN = 1'b1; waitCyc(60);
    chk("R9", "short pulse ignored", {7'd0, resetFlag}, 8'd0);
    hostDataN = ~8'b1000_1000; waitCyc(2); hostSelN = 1'b0; waitCyc(30);
    hostSelN = 1'b1; hostDataN = 8'hFF; waitCyc(5);
    chk("R9", "selected before reset", selStatus, 8'h83);
    hostRstN = 1'b0; waitCyc(80); hostRstN = 1'b1; waitCyc(5);
    chk("R9", "resetFlag", {7'd0, resetFlag}, 8'd1);
    chk("R9", "status cleared", selStatus, 8'h00);
    chk("R9", "bsy released", {7'd0, bsyOutN}, 8'd1);
    chk("R9", "flags cleared", {6'd0, selectedFlag, scsi1Mode}, 8'h00);
    resetAck = 1'b1; waitCyc(1); resetAck = 1'b0; waitCyc(1);
    chk("R10", "resetAck clears", {7'd0, resetFlag}, 8'd0);
  endtask

  task automatic summary();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  endtask

  initial begin
    // entry0 ID3, entry1 ID5, entry2 ID9 (invalid), entry3 ID6 disabled
    cfgTargetId = '0;
    cfgTargetId[0*IW +: IW] = 4'd3;
    cfgTargetId[1*IW +: IW] = 4'd5;
    cfgTargetId[2*IW +: IW] = 4'd9;
    cfgTargetId[3*IW +: IW] = 4'd6;
    cfgTargetEn = 8'b0000_0111;
    waitCyc(4);
    rstN = 1'b1;
    waitCyc(4);
    tReset();
    tScsi1Select();
    tScsi2Select();
    tPriority();
    tBusReset();
    summary();
  end

  initial begin
    #2_000_000;
    compared++;
    mismatched++;
    $display("FAIL watchdog: actual timeout expected completion");
    summary();
  end
endmodule